// File: doc/BRIEF.md
# Register-Mapped Vectored Interrupt Controller

This block collects up to 128 level-sensitive interrupt sources and presents one interrupt request to a processor. Sources are grouped into banks of 32 lines. Software masks and unmasks lines, and raises or withdraws software-forced interrupts, through write-one registers. Each bank has separate registers for setting and for clearing, so no read-modify-write is needed. Source number n lives in bank n>>5 at bit n&31.

The controller is armed after reset. While armed, on each clock edge it picks the lowest-numbered eligible pending line and latches its number. It then raises the interrupt output and disarms. The number stays readable and stable until software issues an end-of-interrupt command, which re-arms the controller. A priority threshold can limit which source numbers may win. A soft reset command restores every software-visible register to its default state. A status bit shows when the soft reset has finished.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After the asynchronous reset, and after a soft reset, the controller is in its default state:
  - every mask bit is 1;
  - every software-trigger bit is 0;
  - the threshold is 0xFF;
  - `irq_o` is low;
  - the active-number register (offset 0x40) reads 0xFFFFFF80;
  - status (0x14) bit 0 reads 1.
- R2: Bank b (0..3) has a mask-clear register at 0x88+0x20*b and a mask-set register at 0x8C+0x20*b.
  - A written 1 bit at position k clears or sets the mask of source 32*b+k.
  - Zero bits leave their lines unchanged.
  - Both addresses read back the current mask word of the bank.
- R3: Bank b has a trigger-set register at 0x90+0x20*b and a trigger-clear register at 0x94+0x20*b, with the same write-one rules as R2.
  - Both addresses read back the current trigger word.
  - A set trigger bit makes its line pending exactly like a high source input.
- R4: A line is pending when its source input or its trigger bit is 1 and its mask bit is 0.
  - While armed, the controller latches the lowest-numbered eligible pending line on a clock edge, disarms, and drives `irq_o` high from that edge on.
- R5: The latched number and `irq_o` are held, whatever the sources do, until a write to 0x48 with bit 0 set (end of interrupt).
  - That write drops `irq_o` at its own edge and re-arms the controller.
  - A new number is latched no earlier than the following edge.
  - A write to 0x48 with bit 0 clear has no effect.
- R6: While a number is latched, 0x40 reads it zero-extended in bits [6:0]. Otherwise 0x40 reads 0xFFFFFF80, whose set upper bits mark the value as spurious.
- R7: The threshold register at 0x68 holds 8 bits.
  - The value 0xFF applies no filtering.
  - Any other value T lets only source numbers below T win arbitration.
- R8: Offset 0x00 reads {24'b0, major[3:0], minor[3:0]}, with defaults major 5 and minor 0. Offset 0x10 and unmapped offsets read 0.
- R9: A write to 0x10 with bit 1 set starts a soft reset that restores the R1 defaults at its edge. For the next SRST_CYCLES (default 4) cycles:
  - status bit 0 reads 0;
  - register writes are ignored;
  - no number is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, a combinational function of `reg_addr` and state |
| src_lvl | input | 128 | Level-sensitive source inputs, source n on bit n |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume a single write strobe per cycle, so a set and a clear to the same bank never collide in one edge. They also assume that `reg_addr` and `reg_wdata` are stable around the sampling edge whenever `reg_wr_en` is high. The bench drives every input one time unit after a rising edge, issues at most one write per cycle, and changes source levels only between edges. Register reads and the `irq_o` level are sampled on the falling edge. Each expected value is predicted from the cycle count since the last write edge: one edge for a mask or trigger change to become pending, and one more for the latch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int REG_W = 32;

  localparam logic [7:0] OFS_REV   = 8'h00;
  localparam logic [7:0] OFS_CFG   = 8'h10;
  localparam logic [7:0] OFS_STAT  = 8'h14;
  localparam logic [7:0] OFS_ACT   = 8'h40;
  localparam logic [7:0] OFS_CTRL  = 8'h48;
  localparam logic [7:0] OFS_THR   = 8'h68;
  localparam logic [7:0] OFS_BANK0 = 8'h88;

  localparam int BANK_STRIDE = 32;

  localparam logic [REG_W-1:0] SPURIOUS_WORD = 32'hFFFF_FF80;
  localparam logic [7:0]       THR_OPEN      = 8'hFF;

  typedef enum logic [1:0] {
    BK_MCLR = 2'd0,
    BK_MSET = 2'd1,
    BK_SSET = 2'd2,
    BK_SCLR = 2'd3
  } bank_op_e;

endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             we,
  input  bank_op_e         op,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] swi_q
);

  logic [LINES-1:0] mask_d;
  logic [LINES-1:0] swi_d;

  always_comb begin
    mask_d = mask_q;
    swi_d  = swi_q;
    if (soft_clr) begin
      mask_d = '1;
      swi_d  = '0;
    end else if (we) begin
      case (op)
        BK_MCLR: mask_d = mask_q & ~wdata;
        BK_MSET: mask_d = mask_q | wdata;
        BK_SSET: swi_d  = swi_q | wdata;
        BK_SCLR: swi_d  = swi_q & ~wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      swi_q  <= '0;
    end else begin
      mask_q <= mask_d;
      swi_q  <= swi_d;
    end
  end

  // R2: a written 1 in mask-set leaves that line masked
  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !soft_clr && op == BK_MSET) |=> ((mask_q & $past(wdata)) == $past(wdata)));

  // R2: zero bits of a mask-clear word leave their lines unchanged
  p_mask_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !soft_clr && op == BK_MCLR) |=> ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));

  // R3: a written 1 in trigger-clear withdraws that trigger
  p_swi_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !soft_clr && op == BK_SCLR) |=> ((swi_q & $past(wdata)) == '0));

endmodule

// File: rtl/irqc_srst.sv
module irqc_srst #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = CNT_W'(CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

  // R9: a soft reset command makes the sequencer busy on the next cycle
  p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R9: once idle, the sequencer stays idle without a new command
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_SRC = 128,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [7:0]         thr,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);

  logic               thr_open;
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] below_win;

  assign thr_open = &thr;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = pend[i] && (thr_open || (i < int'(thr)));
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  assign below_win = (NUM_SRC'(1) << idx) - NUM_SRC'(1);

  always_comb begin
    if (found) begin
      // R4: the chosen line is eligible and no lower line is
      p_winner_elig_r4: assert (elig[idx]);
      p_lowest_wins_r4: assert ((elig & below_win) == '0);
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ADDR_W      = 8,
  parameter int SRST_CYCLES = 4,
  parameter int REV_MAJOR   = 5,
  parameter int REV_MINOR   = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr_en,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [NUM_BANKS*32-1:0]    src_lvl,
  output logic                       irq_o
);

  localparam int LINES     = 32;
  localparam int NUM_SRC   = NUM_BANKS * LINES;
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int BIDX_W    = ADDR_W - 5;
  localparam int BANK_SPAN = NUM_BANKS * BANK_STRIDE;

  // register decode
  logic                 srst_busy;
  logic                 wr_ok;
  logic [ADDR_W-1:0]    bank_off;
  logic                 in_bank;
  bank_op_e             bank_op;
  logic [NUM_BANKS-1:0] bank_we;
  logic                 eoi;
  logic                 srst_start;
  logic                 thr_we;

  assign wr_ok      = reg_wr_en && !srst_busy;
  assign bank_off   = reg_addr - ADDR_W'(OFS_BANK0);
  assign in_bank    = (reg_addr >= ADDR_W'(OFS_BANK0)) && (int'(bank_off) < BANK_SPAN)
                      && !bank_off[4] && (bank_off[1:0] == 2'b00);
  assign bank_op    = bank_op_e'(bank_off[3:2]);
  assign eoi        = wr_ok && (reg_addr == ADDR_W'(OFS_CTRL)) && reg_wdata[0];
  assign srst_start = wr_ok && (reg_addr == ADDR_W'(OFS_CFG)) && reg_wdata[1];
  assign thr_we     = wr_ok && (reg_addr == ADDR_W'(OFS_THR));

  // soft reset sequencer
  irqc_srst #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srst_start),
    .busy  (srst_busy)
  );

  // per-bank mask and trigger registers
  logic [NUM_BANKS-1:0][LINES-1:0] mask_all;
  logic [NUM_BANKS-1:0][LINES-1:0] swi_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_we[b] = wr_ok && in_bank && (bank_off[ADDR_W-1:5] == BIDX_W'(b));

    irqc_bank #(.LINES(LINES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (srst_start),
      .we       (bank_we[b]),
      .op       (bank_op),
      .wdata    (reg_wdata),
      .mask_q   (mask_all[b]),
      .swi_q    (swi_all[b])
    );
  end

  // pending lines and arbitration
  logic [NUM_SRC-1:0] mask_flat;
  logic [NUM_SRC-1:0] swi_flat;
  logic [NUM_SRC-1:0] pend;
  logic               win_found;
  logic [IDX_W-1:0]   win_idx;
  logic [7:0]         thr_q;
  logic [7:0]         thr_d;

  assign mask_flat = mask_all;
  assign swi_flat  = swi_all;
  assign pend      = (src_lvl | swi_flat) & ~mask_flat;

  irqc_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .pend  (pend),
    .thr   (thr_q),
    .found (win_found),
    .idx   (win_idx)
  );

  // latch of the active number
  logic             armed_q, armed_d;
  logic             valid_q, valid_d;
  logic [IDX_W-1:0] num_q, num_d;

  always_comb begin
    armed_d = armed_q;
    valid_d = valid_q;
    num_d   = num_q;
    thr_d   = thr_q;
    if (srst_start) begin
      armed_d = 1'b1;
      valid_d = 1'b0;
      num_d   = '0;
      thr_d   = THR_OPEN;
    end else begin
      if (thr_we) begin
        thr_d = reg_wdata[7:0];
      end
      if (eoi) begin
        armed_d = 1'b1;
        valid_d = 1'b0;
      end else if (armed_q && win_found && !srst_busy) begin
        armed_d = 1'b0;
        valid_d = 1'b1;
        num_d   = win_idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      valid_q <= 1'b0;
      num_q   <= '0;
      thr_q   <= THR_OPEN;
    end else begin
      armed_q <= armed_d;
      valid_q <= valid_d;
      num_q   <= num_d;
      thr_q   <= thr_d;
    end
  end

  assign irq_o = valid_q;

  // read multiplexer
  always_comb begin
    reg_rdata = '0;
    if (in_bank) begin
      if (bank_op == BK_MCLR || bank_op == BK_MSET) begin
        reg_rdata = mask_all[bank_off[ADDR_W-1:5]];
      end else begin
        reg_rdata = swi_all[bank_off[ADDR_W-1:5]];
      end
    end else begin
      case (reg_addr)
        ADDR_W'(OFS_REV):  reg_rdata = {24'b0, 4'(REV_MAJOR), 4'(REV_MINOR)};
        ADDR_W'(OFS_STAT): reg_rdata = {31'b0, !srst_busy};
        ADDR_W'(OFS_ACT):  reg_rdata = valid_q ? {{(32-IDX_W){1'b0}}, num_q} : SPURIOUS_WORD;
        ADDR_W'(OFS_THR):  reg_rdata = {24'b0, thr_q};
        default:           reg_rdata = '0;
      endcase
    end
  end

  // R5: end of interrupt drops the request at its own edge
  p_eoi_drops_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !irq_o);

  // R5: a latched number is held until end of interrupt or soft reset
  p_hold_number_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !eoi && !srst_start) |=> (valid_q && $stable(num_q)));

  // R7: a newly latched number obeys the threshold in force before the edge
  p_thr_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (($past(thr_q) == THR_OPEN) || (int'(num_q) < int'($past(thr_q)))));

  // R9: no number is latched while the soft reset runs
  p_no_latch_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |=> !$rose(irq_o));

endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SPUR = 32'hFFFF_FF80;

  logic         clk;
  logic         rst_n;
  logic         reg_wr_en;
  logic [7:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic [127:0] src_lvl;
  logic         irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  irq_vector_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_lvl   (src_lvl),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [32:0] item;
      logic [31:0] act;
      string       t;
      item = exp_q.pop_front();
      t    = tag_q.pop_front();
      act  = item[32] ? {31'b0, irq_o} : reg_rdata;
      n_tests++;
      if (act !== item[31:0]) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, act, item[31:0]);
      end
    end
  end

  // driver tasks: each starts and ends one time unit after a rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr_en = 1'b1;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    reg_addr = a;
    exp_q.push_back({1'b0, e});
    tag_q.push_back(t);
    @(posedge clk); #1;
  endtask

  task automatic chk_irq(input logic e, input string t);
    exp_q.push_back({1'b1, 31'b0, e});
    tag_q.push_back(t);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    reg_wr_en = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    src_lvl   = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset defaults
    chk_irq(1'b0, "R1 irq low");
    rd(8'h88, 32'hFFFF_FFFF, "R1 bank0 mask");
    rd(8'hEC, 32'hFFFF_FFFF, "R1 bank3 mask");
    rd(8'h90, 32'h0, "R1 bank0 trigger");
    rd(8'h68, 32'hFF, "R1 threshold");
    rd(8'h40, SPUR, "R1 active spurious");
    rd(8'h14, 32'h1, "R1 status");

    // R8 identification and unmapped reads
    rd(8'h00, 32'h50, "R8 revision");
    rd(8'h10, 32'h0, "R8 config reads zero");
    rd(8'h44, 32'h0, "R8 unmapped");

    // R2 mask write-one set/clear on bank 1
    wr(8'hA8, 32'h0000_00F0);
    rd(8'hAC, 32'hFFFF_FF0F, "R2 mask clear");
    wr(8'hAC, 32'h0000_0010);
    rd(8'hA8, 32'hFFFF_FF1F, "R2 mask set");
    wr(8'hA8, 32'h0);
    rd(8'hA8, 32'hFFFF_FF1F, "R2 zero bits unchanged");

    // R4 lowest unmasked wins; line 3 is masked
    src_lvl[39] = 1'b1;
    src_lvl[38] = 1'b1;
    src_lvl[3]  = 1'b1;
    idle(1);
    chk_irq(1'b1, "R4 irq raised");
    rd(8'h40, 32'd38, "R4 lowest wins");

    // R5 hold, then end of interrupt
    src_lvl[38] = 1'b0;
    idle(1);
    chk_irq(1'b1, "R5 irq held");
    rd(8'h40, 32'd38, "R5 number held");
    wr(8'h48, 32'h1);
    chk_irq(1'b0, "R5 eoi drops irq");
    rd(8'h40, SPUR, "R6 spurious after eoi");
    chk_irq(1'b1, "R5 relatched irq");
    rd(8'h40, 32'd39, "R5 new decision");
    wr(8'h48, 32'h2);
    rd(8'h40, 32'd39, "R5 bit0 clear no effect");

    // R3 software triggers on bank 0
    src_lvl = '0;
    wr(8'h48, 32'h1);
    wr(8'h88, 32'h0000_0210);
    wr(8'h90, 32'h0000_0200);
    rd(8'h94, 32'h0000_0200, "R3 trigger set readback");
    rd(8'h40, 32'd9, "R3 trigger pending");
    wr(8'h90, 32'h0000_0010);
    rd(8'h90, 32'h0000_0210, "R3 second trigger");
    rd(8'h40, 32'd9, "R5 hold with lower pending");
    wr(8'h48, 32'h1);
    idle(1);
    rd(8'h40, 32'd4, "R4 lowest trigger wins");
    wr(8'h94, 32'h0000_0010);
    rd(8'h90, 32'h0000_0200, "R3 trigger clear");
    wr(8'h48, 32'h1);
    idle(1);
    rd(8'h40, 32'd9, "R3 remaining trigger");
    wr(8'h94, 32'h0000_0200);
    wr(8'h48, 32'h1);
    idle(2);
    chk_irq(1'b0, "R3 nothing pending");
    rd(8'h40, SPUR, "R6 idle spurious");

    // R7 threshold filtering
    wr(8'h68, 32'h5);
    rd(8'h68, 32'h5, "R7 threshold readback");
    src_lvl[9] = 1'b1;
    idle(2);
    chk_irq(1'b0, "R7 line 9 filtered");
    rd(8'h40, SPUR, "R7 filtered spurious");
    src_lvl[4] = 1'b1;
    idle(1);
    rd(8'h40, 32'd4, "R7 line below threshold");
    src_lvl[4] = 1'b0;
    wr(8'h48, 32'h1);
    idle(2);
    chk_irq(1'b0, "R7 still filtered");
    idle(1);
    wr(8'h68, 32'hFF);
    idle(1);
    rd(8'h40, 32'd9, "R7 open threshold");

    // R9 soft reset
    wr(8'h10, 32'h2);
    chk_irq(1'b0, "R9 irq cleared");
    rd(8'h14, 32'h0, "R9 busy status");
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h88, 32'hFFFF_FFFF, "R9 write ignored");
    rd(8'h14, 32'h0, "R9 last busy cycle");
    rd(8'h14, 32'h1, "R9 done status");
    rd(8'h68, 32'hFF, "R1 threshold after soft reset");
    chk_irq(1'b0, "R1 irq after soft reset");
    rd(8'h90, 32'h0, "R1 trigger after soft reset");
    wr(8'h10, 32'h1);
    rd(8'h14, 32'h1, "R9 bit1 clear no reset");

    // R2/R6 highest line in bank 3
    src_lvl[127] = 1'b1;
    wr(8'hE8, 32'h8000_0000);
    rd(8'hEC, 32'h7FFF_FFFF, "R2 bank3 bit31");
    chk_irq(1'b1, "R6 irq for line 127");
    rd(8'h40, 32'h7F, "R6 number 127");

    idle(1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule